// File: doc/BRIEF.md
# Permutation-Network Survivor Path Unit

This block is the path-history stage of a hard-decision Viterbi decoder for a rate-1/3 convolutional code with constraint length 3, so the trellis has four states. In every cycle the add-compare-select stage hands it one decision bit per state and a one-hot vector that marks the state with the smallest accumulated metric. The decision bit of a state selects which of its two predecessor states survives.

The unit keeps a short per-state history of decision vectors. Each cycle it walks a marker token backwards through a chain of identical stages that copy the trellis. Every stage has one node per state. Each node is a 1-to-2 demultiplexer that its stored decision steers, and each state's inputs are gathered by a 2-input OR gate. The walk uses neither a trace-back memory nor register exchange. The state the token reaches at the far end of the chain yields one decoded bit per cycle, after a fixed latency. A flag marks the output valid once the history holds real decisions that reach back to the first decoded step.

Top module: `perm_survivor_unit`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), valid_o and bit_o read 0, and the decision history, the best-state register and the output are cleared.
- R2: valid_o is low until the 17th rising edge after reset release (trace depth 15 plus 2), goes high at that edge and stays high until the next reset.
- R3: A state index is {newest input bit, previous input bit}, with bit 1 as the MSB. A token at state s in stage j moves to state {s[0], d}, where d is bit s of the decision vector presented j steps before the best vector that launched it. Stage 0 uses the decision vector presented together with that best vector.
- R4: The best vector and decisions sampled at one edge are traced through all 15 stages, and the result is registered at the next edge. bit_o is 1 exactly when the final token sits in state 2 or 3, i.e. when the state MSB is 1.
- R5: When the inputs come from an error-free stream encoded with taps 111, 101 and 011, bit_o reproduces the source bit of the step presented 16 steps before the most recent one.
- R6: A best vector of all zeros launches no token, and the bit produced from that trace is 0.
- R7: Tokens from several states that land on the same node in one stage merge into one token through that node's OR gate. A stage never raises more tokens than it receives.
- R8: With at most one flipped code bit in any 15-symbol window, the decoded stream still matches the source exactly.
- R9: A reset asserted mid-stream drops valid_o and bit_o at once and restarts the 17-edge fill count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_i | input | 4 | Decision bit per state from the add-compare-select stage |
| best_i | input | 4 | One-hot marker of the best-metric state |
| bit_o | output | 1 | Decoded bit |
| valid_o | output | 1 | High once bit_o carries a decoded stream bit |

## Verification
Two behaviours can fall in the same cycle at one node: a demultiplexer steering its own token while a token from the partner state reaches the same OR gate. The bench provokes this by marking states 0 and 2 together in the best vector and forcing their decisions to agree, so both paths meet at stage 1 on every trace. Each result is judged against a bench walk that takes the union of tokens stage by stage, and an assertion checks that no stage ever raises more tokens than it receives. The coded-stream runs take the decisions from an add-compare-select model in the bench and judge the output against the original source bits.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int unsigned DEF_K = 3;

  function automatic int unsigned states_for(int unsigned k);
    return 1 << (k - 1);
  endfunction

  function automatic int unsigned depth_for(int unsigned k);
    return 5 * k;
  endfunction
endpackage

// File: rtl/psu_stage.sv
module psu_stage #(
  parameter int unsigned NS = 4
) (
  input  logic [NS-1:0] tok_i,
  input  logic [NS-1:0] dec_i,
  output logic [NS-1:0] tok_o
);
  localparam int unsigned HALF = NS / 2;

  logic [1:0] dmx [NS];

  // per-node 1-to-2 demux, lane index = decision bit
  for (genvar s = 0; s < NS; s++) begin : g_node
    assign dmx[s] = dec_i[s] ? {tok_i[s], 1'b0} : {1'b0, tok_i[s]};
  end

  // state p collects from the two states whose left shift lands on it
  for (genvar p = 0; p < NS; p++) begin : g_or
    localparam int unsigned SA   = p / 2;
    localparam int unsigned SB   = p / 2 + HALF;
    localparam int unsigned LANE = p % 2;
    assign tok_o[p] = dmx[SA][LANE] | dmx[SB][LANE];
  end

  always_comb begin
    if (!$isunknown(tok_i)) begin
      p_no_split_r7: assert ($countones(tok_o) <= $countones(tok_i))
        else $error("stage raised more tokens than it received");
    end
  end
endmodule

// File: rtl/psu_hist.sv
module psu_hist #(
  parameter int unsigned NS    = 4,
  parameter int unsigned DEPTH = 15
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NS-1:0]              dec_i,
  output logic [DEPTH-1:0][NS-1:0]   hist_o
);
  // slot j holds the decision vector presented j steps ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o <= '0;
    else         hist_o <= {hist_o[DEPTH-2:0], dec_i};
  end
endmodule

// File: rtl/psu_fill.sv
module psu_fill #(
  parameter int unsigned FILL = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  localparam int unsigned CW = $clog2(FILL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (cnt_q != CW'(FILL)) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CW'(FILL));
endmodule

// File: rtl/perm_survivor_unit.sv
module perm_survivor_unit #(
  parameter int unsigned K = psu_pkg::DEF_K
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [psu_pkg::states_for(K)-1:0]    dec_i,
  input  logic [psu_pkg::states_for(K)-1:0]    best_i,
  output logic                                 bit_o,
  output logic                                 valid_o
);
  localparam int unsigned NS    = psu_pkg::states_for(K);
  localparam int unsigned HALF  = NS / 2;
  localparam int unsigned DEPTH = psu_pkg::depth_for(K);
  localparam int unsigned FILL  = DEPTH + 2;
  localparam int unsigned FCW   = $clog2(FILL + 1);

  logic [NS-1:0]            best_q;
  logic [DEPTH-1:0][NS-1:0] hist;
  logic [NS-1:0]            tok [DEPTH+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) best_q <= '0;
    else         best_q <= best_i;
  end

  psu_hist #(.NS(NS), .DEPTH(DEPTH)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec_i),
    .hist_o (hist)
  );

  assign tok[0] = best_q;

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    psu_stage #(.NS(NS)) u_stage (
      .tok_i (tok[j]),
      .dec_i (hist[j]),
      .tok_o (tok[j+1])
    );
  end

  // decoded bit = MSB of the state reached at the far end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_o <= 1'b0;
    else         bit_o <= |tok[DEPTH][NS-1:HALF];
  end

  psu_fill #(.FILL(FILL)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_o (valid_o)
  );

  // edges seen since reset, for the fill-time check
  logic [FCW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   seen_q <= '0;
    else if (seen_q != FCW'(FILL)) seen_q <= seen_q + 1'b1;
  end

  p_valid_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_not_early_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (seen_q == FCW'(FILL)));

  p_token_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(best_q) |-> $onehot0(tok[DEPTH]));

  p_empty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok[DEPTH] == '0) |=> !bit_o);

  p_upper_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tok[DEPTH][NS-1:HALF]) |=> bit_o);
endmodule

// File: tb/perm_survivor_unit_test.sv
module perm_survivor_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS         = 4;
  localparam int DEPTH      = 15;
  localparam int HMAX       = 4096;

  logic       clk_i  = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] dec_i  = '0;
  logic [3:0] best_i = '0;
  logic       bit_o;
  logic       valid_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] dec_h  [HMAX];
  logic [3:0] best_h [HMAX];
  logic       src_h  [HMAX];
  bit         use_src = 1'b0;

  perm_survivor_unit uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (dec_i),
    .best_i  (best_i),
    .bit_o   (bit_o),
    .valid_o (valid_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, int tau, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s step=%0d got=%0b exp=%0b", req, tau, got, exp);
    end
  endtask

  // walk the token union back through DEPTH stages (R3, R6, R7)
  function automatic logic model_bit(int t);
    logic [3:0] tok = best_h[t];
    for (int j = 0; j < DEPTH; j++) begin
      logic [3:0] nt = '0;
      for (int s = 0; s < NS; s++)
        if (tok[s]) nt[((s << 1) | int'(dec_h[t-j][s])) % NS] = 1'b1;
      tok = nt;
    end
    return |tok[3:2];
  endfunction

  // entered and left at a negedge
  task automatic step(logic [3:0] d, logic [3:0] b, int tau, string req);
    dec_i = d; best_i = b;
    dec_h[tau] = d; best_h[tau] = b;
    @(posedge clk_i); #1;
    check("R2", tau, valid_o, logic'(tau >= DEPTH + 1));
    if (tau >= DEPTH + 1) begin
      check(req, tau, bit_o, model_bit(tau - 1));
      if (use_src) check(req, tau, bit_o, src_h[tau-1-DEPTH]);
    end
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; dec_i = '0; best_i = '0;
    #1;
    check("R1", -1, valid_o, 1'b0);
    check("R1", -1, bit_o, 1'b0);
    repeat (2) @(negedge clk_i);
    check("R1", -1, valid_o, 1'b0);
    check("R1", -1, bit_o, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int t = 0; t < 20; t++) step(4'b0000, 4'b0001, t, "R1");
  endtask

  task automatic t_all_ones();
    do_reset();
    for (int t = 0; t < 30; t++) begin
      step(4'b1111, 4'b1 << ($urandom % 4), t, "R4");
      if (t >= DEPTH + 1) check("R4", t, bit_o, 1'b1);
    end
  endtask

  task automatic t_all_zeros();
    do_reset();
    for (int t = 0; t < 30; t++) begin
      step(4'b0000, 4'b1 << ($urandom % 4), t, "R3");
      if (t >= DEPTH + 1) check("R3", t, bit_o, 1'b0);
    end
  endtask

  // one cleared decision for state 3; only the trace that crosses it there at stage 13 flips
  task automatic t_single();
    do_reset();
    for (int t = 0; t < 70; t++) begin
      step((t == 40) ? 4'b0111 : 4'b1111, 4'b0001, t, "R3");
      if (t >= DEPTH + 1) check("R3", t, bit_o, logic'(t != 40 + DEPTH - 1));
    end
  endtask

  task automatic t_empty();
    do_reset();
    for (int t = 0; t < 60; t++) begin
      step(4'b1111, (t == 30) ? 4'b0000 : 4'b0001, t, "R6");
      if (t >= DEPTH + 1) check("R6", t, bit_o, logic'(t != 31));
    end
  endtask

  task automatic t_merge();
    do_reset();
    for (int t = 0; t < 80; t++) begin
      logic [3:0] d = 4'($urandom);
      d[2] = d[0];
      step(d, 4'b0101, t, "R7");
    end
  endtask

  task automatic t_random();
    do_reset();
    for (int t = 0; t < 200; t++) step(4'($urandom), 4'b1 << ($urandom % 4), t, "R3");
  endtask

  task automatic t_coded(int nsteps, bit noisy, string req);
    logic [1:0] sr = '0;
    int pm [4] = '{0, 100, 100, 100};
    do_reset();
    use_src = 1'b1;
    for (int t = 0; t < nsteps; t++) begin
      logic       u = 1'($urandom);
      logic [2:0] sym;
      logic [3:0] dv = '0;
      logic [3:0] bv = '0;
      int         np [4];
      int         mn = 1 << 30;
      src_h[t] = u;
      sym = {u ^ sr[1] ^ sr[0], u ^ sr[0], sr[1] ^ sr[0]};
      sr  = {u, sr[1]};
      if (noisy && (t % 15 == 7)) sym[t % 3] = ~sym[t % 3];
      for (int s = 0; s < NS; s++) begin
        logic [1:0] sv = 2'(s);
        int m [2];
        for (int d = 0; d < 2; d++) begin
          logic [1:0] p = {sv[0], 1'(d)};
          logic [2:0] e = {sv[1] ^ p[1] ^ p[0], sv[1] ^ p[0], p[1] ^ p[0]};
          m[d] = pm[p] + $countones(e ^ sym);
        end
        dv[s] = (m[1] < m[0]);
        np[s] = dv[s] ? m[1] : m[0];
      end
      for (int s = 0; s < NS; s++) if (np[s] < mn) mn = np[s];
      for (int s = NS - 1; s >= 0; s--) if (np[s] == mn) bv = 4'b1 << s;
      for (int s = 0; s < NS; s++) pm[s] = np[s] - mn;
      step(dv, bv, t, req);
    end
    use_src = 1'b0;
  endtask

  task automatic t_mid_reset();
    do_reset();
    for (int t = 0; t < 25; t++) step(4'b1111, 4'b0001, t, "R9");
    rst_ni = 1'b0;
    #1;
    check("R9", -1, valid_o, 1'b0);
    check("R9", -1, bit_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int t = 0; t < 25; t++) step(4'b0000, 4'b1000, t, "R9");
  endtask

  initial begin
    t_reset();
    t_all_ones();
    t_all_zeros();
    t_single();
    t_empty();
    t_merge();
    t_random();
    t_coded(600, 1'b0, "R5");
    t_coded(1500, 1'b1, "R8");
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule